// File: doc/BRIEF.md
# Stack Call/Return Sequencer

This block carries out the stack traffic of an 8-bit processor core: subroutine call and return, software break, return from interrupt, and the single-byte push and pull of the accumulator and the status byte. It holds the stack pointer, the program counter and the status register. It moves one byte per clock over a plain memory port, which has an address, write data, a write strobe and read data. Read data must be valid in the same cycle as its address. The stack always lives in the 256-byte page at 0x0100.

The surrounding core decodes the instruction and raises `start` for one cycle, with a command code and, for a call, the 16-bit target. The program counter here is taken as the address of the next instruction. The sequencer reports `busy` while it runs and pulses `done` once the last transfer is finished. A call saves the next-instruction address minus one, and a return adds the one back. A break saves the exact address and jumps through the vector held at 0xFFFE (low byte) and 0xFFFF (high byte).

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer is 0xFF, the program counter, status and accumulator are 0x00, and `busy`, `done` and `busWrEn` are low.
- R2: A push writes to 0x0100 plus the pointer and then decrements the pointer. A pull first increments the pointer and then reads 0x0100 plus the new value. The pointer wraps modulo 256 in both directions.
- R3: Command codes are 0 call, 1 return, 2 break, 3 return-from-interrupt, 4 push accumulator, 5 push status, 6 pull accumulator and 7 pull status. `start` is taken only while `busy` is low. A `start` raised while busy has no effect on the running sequence and causes no later transfer.
- R4: A call writes the high byte of (PC−1) in its first cycle and the low byte in its second cycle, then loads PC with `target`.
- R5: A return reads the low byte in its first cycle and the high byte in its second cycle, then sets PC to that 16-bit value plus one, wrapping modulo 65536.
- R6: A break writes PC high, PC low and status over three cycles. It then reads 0xFFFE and 0xFFFF in consecutive cycles, loads PC with {0xFFFF byte, 0xFFFE byte} and sets status bit 4. The pushed status is the value held before bit 4 is set.
- R7: A return-from-interrupt reads status, then PC low, then PC high. It restores all eight status bits and loads PC with no increment.
- R8: Push accumulator writes `accIn` in one cycle. Push status writes the status register in one cycle. Pull status loads all eight bits from the read byte in one cycle. Status changes at no other time except under R6 and R9.
- R9: Pull accumulator loads `accOut` with the read byte, sets status bit 7 to the byte's bit 7 and status bit 1 to (byte == 0), and leaves the other status bits unchanged.
- R10: `busy` goes high in the cycle after `start` is accepted and stays high through the last transfer. `done` is high for exactly the one cycle that follows. `busWrEn` is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command strobe |
| cmd | input | 3 | Command code (see R3) |
| target | input | 16 | Call destination |
| accIn | input | 8 | Accumulator value to push |
| rdData | input | 8 | Memory read data, valid in the cycle its address is presented |
| busAddr | output | 16 | Memory address |
| busWrData | output | 8 | Memory write data |
| busWrEn | output | 1 | Memory write strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pcOut | output | 16 | Program counter |
| spOut | output | 8 | Stack pointer |
| statusOut | output | 8 | Status register |
| accOut | output | 8 | Last pulled accumulator value |

## Verification
The bench drives the stack pointer across both wrap points. A push at 0x00 must land at 0x0100 and leave 0xFF, and a pull from 0xFF must read 0x0100; a design that carried into the page byte would touch 0x0000 or 0x0200. Returns from the two nested calls check the −1/+1 pairing, including 0xFFFF+1 wrapping to 0x0000. A design that pushed the exact address on a call, or incremented after a return-from-interrupt, would end one off. The break case checks that the status pushed to the stack lacks the break bit while the register keeps it afterwards. A `start` raised while a break is running must leave no trace on the bus.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [2:0] {
    CMD_CALL      = 3'd0,
    CMD_RET       = 3'd1,
    CMD_BRK       = 3'd2,
    CMD_RTI       = 3'd3,
    CMD_PUSH_ACC  = 3'd4,
    CMD_PUSH_STAT = 3'd5,
    CMD_PULL_ACC  = 3'd6,
    CMD_PULL_STAT = 3'd7
  } seqCmd_e;

  typedef enum logic [2:0] {
    ADR_NONE,
    ADR_PUSH,
    ADR_PULL,
    ADR_VEC_LO,
    ADR_VEC_HI
  } adrSel_e;

  typedef enum logic [2:0] {
    WD_RET_HI,
    WD_RET_LO,
    WD_PC_HI,
    WD_PC_LO,
    WD_STATUS,
    WD_ACC
  } wdSel_e;

  typedef struct packed {
    adrSel_e adrSel;
    logic    wrEn;
    wdSel_e  wdSel;
    logic    spDec;
    logic    spInc;
    logic    ldTmp;
    logic    ldPcTarget;
    logic    ldPcJoin;
    logic    pcPlusOne;
    logic    ldStatus;
    logic    setBrkFlag;
    logic    ldAcc;
  } dpCtl_t;

  localparam int N_BIT   = 7;
  localparam int Z_BIT   = 1;
  localparam int BRK_BIT = 4;
  localparam int STEP_W  = 3;

endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [2:0]           cmd,
  output dpCtl_t               ctl,
  output logic                 busy,
  output logic                 done
);

  logic              running;
  seqCmd_e           cmdQ;
  logic [STEP_W-1:0] step;
  logic              lastStep;

  function automatic logic [STEP_W-1:0] lastStepOf(seqCmd_e c);
    case (c)
      CMD_CALL, CMD_RET: lastStepOf = STEP_W'(1);
      CMD_BRK:           lastStepOf = STEP_W'(4);
      CMD_RTI:           lastStepOf = STEP_W'(2);
      default:           lastStepOf = STEP_W'(0);
    endcase
  endfunction

  assign lastStep = (step == lastStepOf(cmdQ));
  assign busy     = running;

  always_comb begin
    ctl = '0;
    if (running) begin
      case (cmdQ)
        CMD_CALL: begin
          ctl.adrSel = ADR_PUSH;
          ctl.wrEn   = 1'b1;
          ctl.spDec  = 1'b1;
          if (step == 0) ctl.wdSel = WD_RET_HI;
          else begin
            ctl.wdSel      = WD_RET_LO;
            ctl.ldPcTarget = 1'b1;
          end
        end
        CMD_RET: begin
          ctl.adrSel = ADR_PULL;
          ctl.spInc  = 1'b1;
          if (step == 0) ctl.ldTmp = 1'b1;
          else begin
            ctl.ldPcJoin  = 1'b1;
            ctl.pcPlusOne = 1'b1;
          end
        end
        CMD_BRK: begin
          case (step)
            STEP_W'(0), STEP_W'(1), STEP_W'(2): begin
              ctl.adrSel = ADR_PUSH;
              ctl.wrEn   = 1'b1;
              ctl.spDec  = 1'b1;
              ctl.wdSel  = (step == 0) ? WD_PC_HI :
                           (step == 1) ? WD_PC_LO : WD_STATUS;
            end
            STEP_W'(3): begin
              ctl.adrSel = ADR_VEC_LO;
              ctl.ldTmp  = 1'b1;
            end
            default: begin
              ctl.adrSel     = ADR_VEC_HI;
              ctl.ldPcJoin   = 1'b1;
              ctl.setBrkFlag = 1'b1;
            end
          endcase
        end
        CMD_RTI: begin
          ctl.adrSel = ADR_PULL;
          ctl.spInc  = 1'b1;
          if (step == 0)      ctl.ldStatus = 1'b1;
          else if (step == 1) ctl.ldTmp    = 1'b1;
          else                ctl.ldPcJoin = 1'b1;
        end
        CMD_PUSH_ACC, CMD_PUSH_STAT: begin
          ctl.adrSel = ADR_PUSH;
          ctl.wrEn   = 1'b1;
          ctl.spDec  = 1'b1;
          ctl.wdSel  = (cmdQ == CMD_PUSH_ACC) ? WD_ACC : WD_STATUS;
        end
        CMD_PULL_ACC: begin
          ctl.adrSel = ADR_PULL;
          ctl.spInc  = 1'b1;
          ctl.ldAcc  = 1'b1;
        end
        default: begin
          ctl.adrSel   = ADR_PULL;
          ctl.spInc    = 1'b1;
          ctl.ldStatus = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cmdQ    <= CMD_CALL;
      step    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          cmdQ    <= seqCmd_e'(cmd);
          step    <= '0;
        end
      end else if (lastStep) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: an idle start is always taken
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !running) |=> running);

  // R3: a start during a sequence leaves the command untouched
  assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && !lastStep) |=> (running && $stable(cmdQ)));

endmodule

// File: rtl/stack_dp.sv
module stack_dp
  import stack_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] target,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busWrEn,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] accOut
);

  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_ADDR + 1'b1;

  logic [DATA_W-1:0] spReg, spPlus, tmpReg, statusReg, accReg;
  logic [ADDR_W-1:0] pcReg, retAddr, joined;

  assign spPlus  = spReg + 1'b1;
  assign retAddr = pcReg - 1'b1;
  assign joined  = {rdData, tmpReg};

  always_comb begin
    case (ctl.adrSel)
      ADR_PUSH:   busAddr = {STACK_PAGE, spReg};
      ADR_PULL:   busAddr = {STACK_PAGE, spPlus};
      ADR_VEC_LO: busAddr = VEC_ADDR;
      ADR_VEC_HI: busAddr = VEC_HI_ADDR;
      default:    busAddr = '0;
    endcase
  end

  always_comb begin
    case (ctl.wdSel)
      WD_RET_HI: busWrData = retAddr[ADDR_W-1:DATA_W];
      WD_RET_LO: busWrData = retAddr[DATA_W-1:0];
      WD_PC_HI:  busWrData = pcReg[ADDR_W-1:DATA_W];
      WD_PC_LO:  busWrData = pcReg[DATA_W-1:0];
      WD_STATUS: busWrData = statusReg;
      default:   busWrData = accIn;
    endcase
  end

  assign busWrEn   = ctl.wrEn;
  assign pcOut     = pcReg;
  assign spOut     = spReg;
  assign statusOut = statusReg;
  assign accOut    = accReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg     <= '1;
      pcReg     <= '0;
      tmpReg    <= '0;
      statusReg <= '0;
      accReg    <= '0;
    end else begin
      if (ctl.spDec)      spReg <= spReg - 1'b1;
      else if (ctl.spInc) spReg <= spPlus;

      if (ctl.ldTmp) tmpReg <= rdData;

      if (ctl.ldPcTarget)    pcReg <= target;
      else if (ctl.ldPcJoin) pcReg <= ctl.pcPlusOne ? joined + 1'b1 : joined;

      if (ctl.ldStatus) statusReg <= rdData;
      else if (ctl.ldAcc) begin
        statusReg[N_BIT] <= rdData[DATA_W-1];
        statusReg[Z_BIT] <= (rdData == '0);
      end
      if (ctl.setBrkFlag) statusReg[BRK_BIT] <= 1'b1;

      if (ctl.ldAcc) accReg <= rdData;
    end
  end

  // R2: a push leaves the pointer one lower, modulo the page
  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.spDec |=> (spReg == $past(spReg) - 1'b1));

  // R2: a pull leaves the pointer one higher, modulo the page
  assert_pull_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.spInc |=> (spReg == $past(spReg) + 1'b1));

  // R4: the call destination reaches the program counter
  assert_call_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldPcTarget |=> (pcOut == $past(target)));

  // R6: the break flag is set at the end of a break
  assert_brk_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setBrkFlag |=> statusReg[BRK_BIT]);

  // R8: status holds when nothing loads it
  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.ldStatus && !ctl.ldAcc && !ctl.setBrkFlag) |=> $stable(statusReg));

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] target,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busWrEn,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] accOut
);

  dpCtl_t ctl;

  stack_ctrl i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .cmd   (cmd),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  stack_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .target    (target),
    .accIn     (accIn),
    .rdData    (rdData),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWrEn   (busWrEn),
    .pcOut     (pcOut),
    .spOut     (spOut),
    .statusOut (statusOut),
    .accOut    (accOut)
  );

  // R10: no write leaves the block while it is idle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busWrEn);

endmodule

// File: tb/test_stack_seq.sv
`timescale 1ns/1ps
module test_stack_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cmd = '0;
  logic [15:0] target = '0;
  logic [7:0]  accIn = '0;
  logic [7:0]  rdData;
  logic [15:0] busAddr;
  logic [7:0]  busWrData;
  logic        busWrEn, busy, done;
  logic [15:0] pcOut;
  logic [7:0]  spOut, statusOut, accOut;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  localparam logic [7:0] VEC_LO = 8'h34;
  localparam logic [7:0] VEC_HI = 8'h12;

  logic [7:0] stackMem [256];

  // reference model state
  logic [7:0]  mSp, mSt, mAcc;
  logic [15:0] mPc;

  always #2.5 clk = ~clk;

  stack_seq i_stack_seq (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .target(target),
    .accIn(accIn), .rdData(rdData), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busy(busy), .done(done), .pcOut(pcOut), .spOut(spOut),
    .statusOut(statusOut), .accOut(accOut)
  );

  always_comb begin
    if (busAddr[15:8] == 8'h01)   rdData = stackMem[busAddr[7:0]];
    else if (busAddr == 16'hFFFE) rdData = VEC_LO;
    else if (busAddr == 16'hFFFF) rdData = VEC_HI;
    else                          rdData = 8'h00;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) stackMem[i] <= 8'h00;
    end else if (busWrEn && busAddr[15:8] == 8'h01) begin
      stackMem[busAddr[7:0]] <= busWrData;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nFail++;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xferW(string req, logic [15:0] a, logic [7:0] d);
    checkEq(req, "addr", busAddr, a);
    checkEq(req, "wrEn", busWrEn, 1);
    checkEq(req, "wrData", busWrData, d);
    checkEq(req, "busy", busy, 1);
    checkEq(req, "done", done, 0);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic xferR(string req, logic [15:0] a, output logic [7:0] d);
    checkEq(req, "addr", busAddr, a);
    checkEq(req, "wrEn", busWrEn, 0);
    checkEq(req, "busy", busy, 1);
    checkEq(req, "done", done, 0);
    d = rdData;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic checkState(string req);
    checkEq(req, "pc", pcOut, mPc);
    checkEq(req, "sp", spOut, mSp);
    checkEq(req, "status", statusOut, mSt);
    checkEq(req, "acc", accOut, mAcc);
  endtask

  task automatic runCmd(logic [2:0] c, logic [15:0] tgt, logic [7:0] acc, bit poke);
    logic [15:0] r;
    logic [7:0] lo, hi, v;
    start = 1'b1; cmd = c; target = tgt; accIn = acc;
    @(negedge clk);
    start = poke;
    if (poke) cmd = 3'd4;
    case (c)
      3'd0: begin // R4
        r = mPc - 16'd1;
        xferW("R4", {8'h01, mSp}, r[15:8]); mSp--;
        xferW("R4", {8'h01, mSp}, r[7:0]);  mSp--;
        mPc = tgt;
      end
      3'd1: begin // R5
        mSp++; xferR("R5", {8'h01, mSp}, lo);
        mSp++; xferR("R5", {8'h01, mSp}, hi);
        mPc = {hi, lo} + 16'd1;
      end
      3'd2: begin // R6
        xferW("R6", {8'h01, mSp}, mPc[15:8]); mSp--;
        xferW("R6", {8'h01, mSp}, mPc[7:0]);  mSp--;
        xferW("R6", {8'h01, mSp}, mSt);       mSp--;
        xferR("R6", 16'hFFFE, lo);
        xferR("R6", 16'hFFFF, hi);
        mPc = {hi, lo};
        mSt = mSt | 8'h10;
      end
      3'd3: begin // R7
        mSp++; xferR("R7", {8'h01, mSp}, v); mSt = v;
        mSp++; xferR("R7", {8'h01, mSp}, lo);
        mSp++; xferR("R7", {8'h01, mSp}, hi);
        mPc = {hi, lo};
      end
      3'd4: begin xferW("R8", {8'h01, mSp}, acc); mSp--; end
      3'd5: begin xferW("R8", {8'h01, mSp}, mSt); mSp--; end
      3'd6: begin // R9
        mSp++; xferR("R9", {8'h01, mSp}, v);
        mAcc = v; mSt[7] = v[7]; mSt[1] = (v == 8'h00);
      end
      default: begin
        mSp++; xferR("R8", {8'h01, mSp}, v); mSt = v;
      end
    endcase
    checkEq("R10", "done after last", done, 1);
    checkEq("R10", "busy after last", busy, 0);
    checkEq("R10", "idle wrEn", busWrEn, 0);
    checkState("R2");
    @(negedge clk);
    checkEq("R10", "done one cycle", done, 0);
    if (poke) begin
      checkEq("R3", "busy after ignored start", busy, 0);
      checkEq("R3", "no stray write", busWrEn, 0);
      checkState("R3");
    end
  endtask

  initial begin
    mSp = 8'hFF; mPc = 16'h0000; mSt = 8'h00; mAcc = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkEq("R1", "sp", spOut, 8'hFF);
    checkEq("R1", "pc", pcOut, 16'h0000);
    checkEq("R1", "status", statusOut, 8'h00);
    checkEq("R1", "acc", accOut, 8'h00);
    checkEq("R1", "busy", busy, 0);
    checkEq("R1", "done", done, 0);
    checkEq("R1", "wrEn", busWrEn, 0);
    rstN = 1'b1;
    @(negedge clk);

    runCmd(3'd4, 16'h0, 8'hC3, 0);  // push acc at 01FF
    runCmd(3'd7, 16'h0, 8'h00, 0);  // pull status: C3
    runCmd(3'd7, 16'h0, 8'h00, 0);  // R2 pull wraps FF->00
    runCmd(3'd4, 16'h0, 8'hA5, 0);  // R2 push wraps 00->FF
    runCmd(3'd6, 16'h0, 8'h00, 0);  // R9 negative value
    runCmd(3'd4, 16'h0, 8'h00, 0);
    runCmd(3'd6, 16'h0, 8'h00, 0);  // R9 zero value
    runCmd(3'd4, 16'h0, 8'hC3, 0);
    runCmd(3'd7, 16'h0, 8'h00, 0);  // R8 status restore
    runCmd(3'd5, 16'h0, 8'h00, 0);  // R8 push status
    runCmd(3'd0, 16'h2000, 8'h00, 0); // R4 call from pc 0000
    runCmd(3'd0, 16'h3456, 8'h00, 0); // R4 nested call
    runCmd(3'd1, 16'h0, 8'h00, 0);  // R5 return
    runCmd(3'd2, 16'h0, 8'h00, 1);  // R6 break, R3 start while busy
    runCmd(3'd3, 16'h0, 8'h00, 0);  // R7 return from interrupt
    runCmd(3'd1, 16'h0, 8'h00, 0);  // R5 return wraps FFFF+1

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule